// File: doc/BRIEF.md
# Handshake GCD Datapath

This block is the arithmetic half of a greatest-common-divisor engine whose sequencing lives elsewhere. It keeps two 8-bit operand registers, called A and B. Each register has a multiplexer in front of it that takes either a fresh external operand or the output of that register's own subtractor. A magnitude comparator watches both registers. A result register returns the common value once the two operands have met.

Every action is started by raising a request line and finishes when the matching acknowledge rises. The protocol is four-phase: the request is dropped only after its acknowledge is seen, and the acknowledge returns low one clock after the request falls. An action takes effect on the clock edge where its request is first seen high. That edge also raises the acknowledge, so completion is always one clock after the request. An external controller loads both operands and then repeats a loop: compare, then subtract on the branch the comparator reports. When the comparator reports equality, the controller requests the result.

The comparator answers through three separate acknowledge wires, one for each ordering, rather than through flag bits. Its verdict is frozen for the whole handshake.

Top module: `gcd_hs_datapath`

## Requirements
- R1: While reset is high and on the first cycle after it, every acknowledge is 0 and `res_out` is 0. Both operand registers reset to 0.
- R2: Each acknowledge rises one clock after its request rises and falls one clock after that request falls. For the compare channel the acknowledge is the OR of `gt_ack`, `eq_ack` and `lt_ack`.
- R3: On the clock edge where `a_load_req` is first seen high, A takes `a_in`. On the edge where `b_load_req` is first seen high, B takes `b_in`.
- R4: While the compare acknowledge is high, exactly one of the three wires is 1. `gt_ack` means A > B, `eq_ack` means A == B, and `lt_ack` means A < B, judged on the register values at the edge where `cmp_req` was first seen high.
- R5: The compare verdict stays stable for the whole handshake, even when A or B change while `cmp_req` is held.
- R6: An accepted A-subtract replaces A with A − B, but only if A > B at that edge. Otherwise A is left unchanged and the handshake still completes.
- R7: An accepted B-subtract replaces B with B − A, but only if B > A at that edge. Otherwise B is left unchanged and the handshake still completes.
- R8: An accepted result request copies A to `res_out` when A == B. Otherwise `res_out` keeps its previous value. After a full compare and subtract loop, `res_out` equals the GCD of the loaded operands.
- R9: When a load and a subtract for the same register are accepted on the same edge, the load wins.
- R10: `a_in` and `b_in` are sampled only on an accepted load. A change at any other time has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | External operand for register A |
| b_in | input | 8 | External operand for register B |
| a_load_req | input | 1 | Request to load A from `a_in` |
| a_load_ack | output | 1 | Acknowledge for the A load |
| b_load_req | input | 1 | Request to load B from `b_in` |
| b_load_ack | output | 1 | Acknowledge for the B load |
| cmp_req | input | 1 | Compare request |
| gt_ack | output | 1 | Compare acknowledge, A greater than B |
| eq_ack | output | 1 | Compare acknowledge, A equal to B |
| lt_ack | output | 1 | Compare acknowledge, A less than B |
| a_sub_req | input | 1 | Request A ← A − B |
| a_sub_ack | output | 1 | Acknowledge for the A subtract |
| b_sub_req | input | 1 | Request B ← B − A |
| b_sub_ack | output | 1 | Acknowledge for the B subtract |
| res_req | input | 1 | Result request |
| res_ack | output | 1 | Result acknowledge |
| res_out | output | 8 | GCD result |

## Verification
Directed sequences cover the following cases:
- Equal operands, where the first compare gives equality with no subtraction.
- A subtract requested against the wrong ordering, which must leave the register untouched and separates a guarded subtractor from a plain one.
- A compare held open while its operand is subtracted past the other, which separates a latched verdict from a live one.
- A simultaneous load and subtract, which exposes the multiplexer priority.
- An operand change without a load, which shows whether the inputs are sampled outside a load.

Random nonzero operand pairs from a fixed seed, plus corners such as (1, 255), (255, 255) and (128, 64), then drive the complete loop. Every compare is checked against a bench model of both registers, and the final result is checked against a Euclid reference, which catches wrong difference directions and wrong branch decoding.

// File: rtl/gcd_hs_pkg.sv
package gcd_hs_pkg;

    localparam int unsigned GCD_W = 8;

    // Handshake channel indices inside the request/acknowledge vectors
    localparam int CH_LDA  = 0;
    localparam int CH_LDB  = 1;
    localparam int CH_CMP  = 2;
    localparam int CH_SUBA = 3;
    localparam int CH_SUBB = 4;
    localparam int CH_RES  = 5;
    localparam int NCH     = 6;

    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_LT = 2'd2
    } cmp_code_e;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_DIFF = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } mag_flags_t;

    function automatic cmp_code_e encode_flags(input mag_flags_t f);
        cmp_code_e c;
        if (f.gt)      c = CMP_GT;
        else if (f.lt) c = CMP_LT;
        else           c = CMP_EQ;
        return c;
    endfunction

    // Load has priority over a subtraction on the same register
    function automatic src_sel_e pick_source(input logic load, input logic sub_ok);
        src_sel_e s;
        if (load)        s = SRC_EXT;
        else if (sub_ok) s = SRC_DIFF;
        else             s = SRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/hs_channel.sv
module hs_channel (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ack,
    output logic start
);
    logic ack_q;

    // Acknowledge mirrors the request one clock later
    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= req;
    end

    // The action fires on the edge where the request is high but not yet acknowledged
    assign start = req & ~ack_q;
    assign ack   = ack_q;
endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import gcd_hs_pkg::*;
#(
    parameter int unsigned W = GCD_W
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output mag_flags_t   flags
);
    always_comb begin
        flags.gt = (lhs > rhs);
        flags.lt = (lhs < rhs);
        flags.eq = (lhs == rhs);
    end
endmodule

// File: rtl/operand_reg.sv
module operand_reg
    import gcd_hs_pkg::*;
#(
    parameter int unsigned W = GCD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         sub_ok,
    input  logic [W-1:0] ext,
    input  logic [W-1:0] other,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;
    logic [W-1:0] diff;
    logic [W-1:0] nxt;
    src_sel_e     sel;

    assign diff = q_r - other;
    assign sel  = pick_source(load, sub_ok);

    always_comb begin
        case (sel)
            SRC_EXT:  nxt = ext;
            SRC_DIFF: nxt = diff;
            default:  nxt = q_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/gcd_hs_datapath.sv
module gcd_hs_datapath
    import gcd_hs_pkg::*;
#(
    parameter int unsigned W = GCD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_load_req,
    output logic         a_load_ack,
    input  logic         b_load_req,
    output logic         b_load_ack,
    input  logic         cmp_req,
    output logic         gt_ack,
    output logic         eq_ack,
    output logic         lt_ack,
    input  logic         a_sub_req,
    output logic         a_sub_ack,
    input  logic         b_sub_req,
    output logic         b_sub_ack,
    input  logic         res_req,
    output logic         res_ack,
    output logic [W-1:0] res_out
);
    logic [NCH-1:0] req_vec;
    logic [NCH-1:0] ack_vec;
    logic [NCH-1:0] start_vec;

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [W-1:0] res_q;
    mag_flags_t   flags;
    cmp_code_e    cmp_q;

    assign req_vec[CH_LDA]  = a_load_req;
    assign req_vec[CH_LDB]  = b_load_req;
    assign req_vec[CH_CMP]  = cmp_req;
    assign req_vec[CH_SUBA] = a_sub_req;
    assign req_vec[CH_SUBB] = b_sub_req;
    assign req_vec[CH_RES]  = res_req;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hs_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .req   (req_vec[i]),
            .ack   (ack_vec[i]),
            .start (start_vec[i])
        );
    end

    mag_compare #(.W(W)) u_cmp (
        .lhs   (a_q),
        .rhs   (b_q),
        .flags (flags)
    );

    // A subtracts only when A > B, B only when B > A: no underflow
    operand_reg #(.W(W)) u_reg_a (
        .clk    (clk),
        .rst    (rst),
        .load   (start_vec[CH_LDA]),
        .sub_ok (start_vec[CH_SUBA] & flags.gt),
        .ext    (a_in),
        .other  (b_q),
        .q      (a_q)
    );

    operand_reg #(.W(W)) u_reg_b (
        .clk    (clk),
        .rst    (rst),
        .load   (start_vec[CH_LDB]),
        .sub_ok (start_vec[CH_SUBB] & flags.lt),
        .ext    (b_in),
        .other  (a_q),
        .q      (b_q)
    );

    // Verdict frozen on the opening edge of the compare handshake
    always_ff @(posedge clk) begin
        if (rst)                    cmp_q <= CMP_EQ;
        else if (start_vec[CH_CMP]) cmp_q <= encode_flags(flags);
    end

    always_ff @(posedge clk) begin
        if (rst)                               res_q <= '0;
        else if (start_vec[CH_RES] && flags.eq) res_q <= a_q;
    end

    assign a_load_ack = ack_vec[CH_LDA];
    assign b_load_ack = ack_vec[CH_LDB];
    assign a_sub_ack  = ack_vec[CH_SUBA];
    assign b_sub_ack  = ack_vec[CH_SUBB];
    assign res_ack    = ack_vec[CH_RES];
    assign gt_ack     = ack_vec[CH_CMP] & (cmp_q == CMP_GT);
    assign eq_ack     = ack_vec[CH_CMP] & (cmp_q == CMP_EQ);
    assign lt_ack     = ack_vec[CH_CMP] & (cmp_q == CMP_LT);
    assign res_out    = res_q;
endmodule

// File: rtl/gcd_hs_checker.sv
module gcd_hs_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         a_load_req,
    input logic         a_load_ack,
    input logic         b_load_req,
    input logic         b_load_ack,
    input logic         cmp_req,
    input logic         gt_ack,
    input logic         eq_ack,
    input logic         lt_ack,
    input logic         a_sub_req,
    input logic         a_sub_ack,
    input logic         b_sub_req,
    input logic         b_sub_ack,
    input logic         res_req,
    input logic         res_ack,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic [W-1:0] res_out
);
    logic armed;
    logic cmp_any;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign cmp_any = gt_ack | eq_ack | lt_ack;

    // R2: every acknowledge follows its request by one clock
    p_ack_follow_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        {a_load_ack, b_load_ack, cmp_any, a_sub_ack, b_sub_ack, res_ack}
            == $past({a_load_req, b_load_req, cmp_req, a_sub_req, b_sub_req, res_req}));

    // R4: never more than one compare wire
    p_cmp_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gt_ack, eq_ack, lt_ack}));

    // R4: an open compare handshake shows exactly one verdict
    p_cmp_answer_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(cmp_req) |-> $countones({gt_ack, eq_ack, lt_ack}) == 1);

    // R5: verdict stable while the acknowledge stays high
    p_cmp_stable_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmp_any && $past(cmp_any)) |-> $stable({gt_ack, eq_ack, lt_ack}));

    // R6: refused A-subtract leaves A untouched
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(a_sub_req && !a_sub_ack && !(a_load_req && !a_load_ack) && (a_q <= b_q))
            |-> a_q == $past(a_q));

    // R7: refused B-subtract leaves B untouched
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(b_sub_req && !b_sub_ack && !(b_load_req && !b_load_ack) && (b_q <= a_q))
            |-> b_q == $past(b_q));

    // R8: result copies A when the operands match
    p_result_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(res_req && !res_ack && (a_q == b_q)) |-> res_out == $past(a_q));
endmodule

bind gcd_hs_datapath gcd_hs_checker #(.W(W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .a_load_req (a_load_req),
    .a_load_ack (a_load_ack),
    .b_load_req (b_load_req),
    .b_load_ack (b_load_ack),
    .cmp_req    (cmp_req),
    .gt_ack     (gt_ack),
    .eq_ack     (eq_ack),
    .lt_ack     (lt_ack),
    .a_sub_req  (a_sub_req),
    .a_sub_ack  (a_sub_ack),
    .b_sub_req  (b_sub_req),
    .b_sub_ack  (b_sub_ack),
    .res_req    (res_req),
    .res_ack    (res_ack),
    .a_q        (a_q),
    .b_q        (b_q),
    .res_out    (res_out)
);

// File: tb/test_gcd_hs_datapath.sv
`timescale 1ns/1ps
module test_gcd_hs_datapath;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic a_load_req, a_load_ack, b_load_req, b_load_ack;
    logic cmp_req, gt_ack, eq_ack, lt_ack;
    logic a_sub_req, a_sub_ack, b_sub_req, b_sub_ack;
    logic res_req, res_ack;
    logic [W-1:0] res_out;

    int n_cmp = 0;
    int n_bad = 0;
    int ma = 0, mb = 0, mres = 0;

    always #5 clk = ~clk;

    gcd_hs_datapath #(.W(W)) i_gcd_hs_datapath (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_load_req(a_load_req), .a_load_ack(a_load_ack),
        .b_load_req(b_load_req), .b_load_ack(b_load_ack),
        .cmp_req(cmp_req), .gt_ack(gt_ack), .eq_ack(eq_ack), .lt_ack(lt_ack),
        .a_sub_req(a_sub_req), .a_sub_ack(a_sub_ack),
        .b_sub_req(b_sub_req), .b_sub_ack(b_sub_ack),
        .res_req(res_req), .res_ack(res_ack), .res_out(res_out)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int ch, input logic v);
        case (ch)
            0: a_load_req = v;
            1: b_load_req = v;
            2: cmp_req    = v;
            3: a_sub_req  = v;
            4: b_sub_req  = v;
            default: res_req = v;
        endcase
    endtask

    function automatic logic get_ack(input int ch);
        case (ch)
            0: return a_load_ack;
            1: return b_load_ack;
            2: return gt_ack | eq_ack | lt_ack;
            3: return a_sub_ack;
            4: return b_sub_ack;
            default: return res_ack;
        endcase
    endfunction

    // Full four-phase handshake; returns at a falling edge
    task automatic pulse(input int ch);
        @(negedge clk);
        set_req(ch, 1'b1);
        @(negedge clk);
        check(get_ack(ch) == 1'b1, $sformatf("R2 ack rise ch%0d", ch), int'(get_ack(ch)), 1);
        set_req(ch, 1'b0);
        @(negedge clk);
        check(get_ack(ch) == 1'b0, $sformatf("R2 ack fall ch%0d", ch), int'(get_ack(ch)), 0);
    endtask

    function automatic int code_of(input logic g, input logic e, input logic l);
        if ({g, e, l} == 3'b100) return 0;
        if ({g, e, l} == 3'b010) return 1;
        if ({g, e, l} == 3'b001) return 2;
        return 3;
    endfunction

    function automatic int exp_code(input int x, input int y);
        if (x > y) return 0;
        if (x == y) return 1;
        return 2;
    endfunction

    function automatic int ref_gcd(input int x, input int y);
        int p = x, q = y, t;
        while (q != 0) begin t = p % q; p = q; q = t; end
        return p;
    endfunction

    task automatic do_compare(output int code);
        @(negedge clk);
        cmp_req = 1'b1;
        @(negedge clk);
        code = code_of(gt_ack, eq_ack, lt_ack);
        check($countones({gt_ack, eq_ack, lt_ack}) == 1, "R4 one verdict",
              $countones({gt_ack, eq_ack, lt_ack}), 1);
        cmp_req = 1'b0;
        @(negedge clk);
        check(get_ack(2) == 1'b0, "R2 compare ack fall", int'(get_ack(2)), 0);
    endtask

    task automatic cmp_expect(input string tag);
        int c;
        do_compare(c);
        check(c == exp_code(ma, mb), tag, c, exp_code(ma, mb));
    endtask

    task automatic load_both(input int x, input int y);
        a_in = x[W-1:0];
        b_in = y[W-1:0];
        pulse(0);
        pulse(1);
        ma = x; mb = y;
    endtask

    task automatic sub_a();
        pulse(3);
        if (ma > mb) ma = ma - mb;
    endtask

    task automatic sub_b();
        pulse(4);
        if (mb > ma) mb = mb - ma;
    endtask

    task automatic result_expect(input string tag);
        pulse(5);
        if (ma == mb) mres = ma;
        check(int'(res_out) == mres, tag, int'(res_out), mres);
    endtask

    task automatic run_gcd(input int x, input int y);
        int c;
        load_both(x, y);
        for (int it = 0; it < 600; it++) begin
            do_compare(c);
            check(c == exp_code(ma, mb), "R4 loop verdict", c, exp_code(ma, mb));
            if (c == 1 || c == 3) break;
            if (c == 0) sub_a();
            else        sub_b();
        end
        pulse(5);
        if (ma == mb) mres = ma;
        check(int'(res_out) == ref_gcd(x, y),
              $sformatf("R8 gcd(%0d,%0d)", x, y), int'(res_out), ref_gcd(x, y));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        a_load_req = 0; b_load_req = 0; cmp_req = 0;
        a_sub_req = 0; b_sub_req = 0; res_req = 0;
        void'($urandom(32'h0000_6cd5));
        repeat (3) @(negedge clk);
        check({a_load_ack, b_load_ack, gt_ack, eq_ack, lt_ack, a_sub_ack, b_sub_ack, res_ack} == 8'h00,
              "R1 acks in reset", 1, 0);
        check(res_out == '0, "R1 result in reset", int'(res_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(res_out == '0, "R1 result after reset", int'(res_out), 0);
        cmp_expect("R1 registers zero after reset");

        // R3: equal load, immediate result
        load_both(37, 37);
        cmp_expect("R3 equal load verdict");
        result_expect("R8 equal result");

        // R6: A-subtract against the wrong ordering is refused
        load_both(5, 9);
        sub_a();
        cmp_expect("R6 refused A subtract");
        result_expect("R8 unequal keeps result");
        sub_b();
        cmp_expect("R7 accepted B subtract");
        // R7: B-subtract against the wrong ordering is refused
        sub_b();
        cmp_expect("R7 refused B subtract");

        // R10: input change without a load is ignored
        a_in = 8'd1;
        b_in = 8'd200;
        repeat (2) @(negedge clk);
        cmp_expect("R10 inputs ignored outside load");

        // R5: verdict held while A drops below B
        load_both(20, 8);
        @(negedge clk);
        cmp_req = 1'b1;
        @(negedge clk);
        check(gt_ack == 1'b1, "R5 verdict opens gt", int'(gt_ack), 1);
        for (int k = 0; k < 2; k++) begin
            a_sub_req = 1'b1;
            @(negedge clk);
            a_sub_req = 1'b0;
            @(negedge clk);
            ma = ma - mb;
        end
        check({gt_ack, eq_ack, lt_ack} == 3'b100, "R5 verdict stable",
              int'({gt_ack, eq_ack, lt_ack}), 4);
        cmp_req = 1'b0;
        @(negedge clk);
        check(get_ack(2) == 1'b0, "R2 held compare ack fall", int'(get_ack(2)), 0);
        cmp_expect("R5 fresh verdict after change");

        // R9: load beats subtract on the same edge
        load_both(10, 3);
        a_in = 8'd50;
        @(negedge clk);
        a_load_req = 1'b1;
        a_sub_req  = 1'b1;
        @(negedge clk);
        a_load_req = 1'b0;
        a_sub_req  = 1'b0;
        @(negedge clk);
        ma = 50;
        b_in = 8'd50;
        pulse(1);
        mb = 50;
        cmp_expect("R9 load wins over subtract");

        // Full loop corners and random pairs
        run_gcd(1, 255);
        run_gcd(255, 255);
        run_gcd(128, 64);
        run_gcd(64, 128);
        for (int n = 0; n < 30; n++) begin
            int x, y;
            x = int'($urandom_range(255, 1));
            y = int'($urandom_range(255, 1));
            run_gcd(x, y);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule